// File: doc/BRIEF.md
# One-Level Karatsuba Binary Polynomial Multiplier

This block multiplies two dense binary polynomials, each with fewer than P coefficients, and returns their product reduced modulo x^P + 1. Each operand is cut at a split point of S bits into a low half and a high half. Every half lives in its own small memory. The three half-size carry-less products are worked out one after another on a single shared word-by-word schoolbook unit. The low product is formed first, then the middle one on the half-sums, then the high one.

Because the coefficients live in GF(2), every Karatsuba addition and subtraction is a bitwise XOR. The half-sums are formed as words leave the operand memories on their way into the multiplier. The recombination and the fold of the upper product bits onto the lower P bits are applied on the way out, while result words are streamed.

A host drives a request together with an opcode. Operand words arrive over one shared BW-bit bus. A one-cycle acknowledge closes every operation, and a readout returns ceil(P/BW) result words, each marked with valid.

Top module: `kara_mul`

## Requirements
- R1: The opcode sampled with `req_i` while the block is idle selects the operation: 0 loads operand A, 1 loads operand B, 2 multiplies, 3 reads out the result.
- R2: A load samples `data_i` in the request cycle and in the following NW-1 cycles (NW = ceil(P/BW)), least significant word first. Bit k of word w is coefficient w·BW+k. Bits at positions P and above are ignored. The load occupies 2·ceil(NW/2) cycles.
- R3: After a multiply, the readout equals A·B mod (x^P + 1) over GF(2).
- R4: A readout delivers exactly NW words on consecutive cycles with `valid_o` high, least significant word first. `ack_o` is high together with the last word, and bits of that word at coefficient positions P and above are zero.
- R5: `ack_o` is a pulse of exactly one cycle that ends each load, multiply and readout.
- R6: A request made while a multiply is still in progress is ignored, and the operands and the result are left unchanged.
- R7: Operands stay stored across multiplies, so reloading only one operand suffices. Readout does not disturb the stored result, so a second readout returns the same words.
- R8: During and right after a synchronous reset, `valid_o` and `ack_o` are low.
- R9: The split point S equals ceil(NW/2)·BW bits. Products of every pair of monomials, including pairs on opposite sides of the split and pairs whose degree sum reaches P or more, are correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Starts an operation when the block is idle |
| op_i | input | 2 | Operation code (R1) |
| data_i | input | BW | Operand word bus shared by A and B |
| res_o | output | BW | Result word stream |
| valid_o | output | 1 | Marks a valid result word |
| ack_o | output | 1 | One-cycle end-of-operation pulse |

## Verification
A wrong operand half, a mis-ordered Karatsuba phase or a lost carry in the column accumulator corrupts specific coefficients. These show up in the very next readout after the multiply. Monomial pairs place a single 1 at (i+j) mod P, so each such fault shows at a predictable bit. A sequencing error in the load or readout counters shows within one operation, as a wrong word count, a gap in `valid_o` or a misplaced acknowledge. A request that leaks in while a multiply is running shows as a changed product in the readout that follows.

// File: rtl/kara_pkg.sv
package kara_pkg;
  typedef enum logic [1:0] {
    OPC_LOAD_A = 2'd0,
    OPC_LOAD_B = 2'd1,
    OPC_MULT   = 2'd2,
    OPC_READ   = 2'd3
  } kara_op_e;

  typedef enum logic [1:0] {
    PH_LOW  = 2'd0,
    PH_MID  = 2'd1,
    PH_HIGH = 2'd2
  } kara_phase_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_MUL  = 2'd2,
    ST_READ = 2'd3
  } kara_state_e;
endpackage

// File: rtl/kara_half_mem.sv
// One operand half: simple dual-port memory with registered read.
module kara_half_mem #(
  parameter int DW    = 8,
  parameter int DEPTH = 4,
  parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/kara_clmul.sv
// Word-by-word carry-less product.
module kara_clmul #(
  parameter int BW = 8
) (
  input  logic [BW-1:0]   a,
  input  logic [BW-1:0]   b,
  output logic [2*BW-1:0] p
);
  always_comb begin
    p = '0;
    for (int i = 0; i < BW; i++) begin
      if (b[i]) p = p ^ ({{BW{1'b0}}, a} << i);
    end
  end
endmodule

// File: rtl/kara_result_bank.sv
// Three half-product buffers; recombination and fold applied on the read side.
module kara_result_bank #(
  parameter int P  = 13,
  parameter int BW = 4,
  parameter int HW = 2,
  parameter int KW = 3,
  parameter int NW = 4
) (
  input  logic             clk,
  input  logic             we,
  input  logic [1:0]       sel,
  input  logic [KW-1:0]    waddr,
  input  logic [BW-1:0]    wdata,
  output logic [NW*BW-1:0] cvec
);
  localparam int CW = 2 * HW;
  localparam int YB = CW * BW;
  localparam int ZW = 2 * YB;

  logic [YB-1:0] yflat [3];

  for (genvar g = 0; g < 3; g++) begin : g_ph
    logic [BW-1:0] ybuf [CW];
    always_ff @(posedge clk) begin
      if (we && sel == 2'(g)) ybuf[waddr] <= wdata;
    end
    for (genvar x = 0; x < CW; x++) begin : g_w
      assign yflat[g][x*BW +: BW] = ybuf[x];
    end
  end

  logic [YB-1:0] mid;
  logic [ZW-1:0] z;
  logic [P-1:0]  red;

  always_comb begin
    mid  = yflat[0] ^ yflat[1] ^ yflat[2];
    z    = {{YB{1'b0}}, yflat[0]}
         ^ ({{YB{1'b0}}, mid} << (HW * BW))
         ^ {yflat[2], {YB{1'b0}}};
    red  = z[P-1:0] ^ z[2*P-1:P];
    cvec = '0;
    cvec[P-1:0] = red;
  end
endmodule

// File: rtl/kara_mul.sv
module kara_mul
  import kara_pkg::*;
#(
  parameter int P  = 13,
  parameter int BW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_i,
  input  logic [1:0]    op_i,
  input  logic [BW-1:0] data_i,
  output logic [BW-1:0] res_o,
  output logic          valid_o,
  output logic          ack_o
);
  localparam int NW = (P + BW - 1) / BW;
  localparam int HW = (NW + 1) / 2;
  localparam int CW = 2 * HW;
  localparam int AW = (HW > 1) ? $clog2(HW) : 1;
  localparam int KW = $clog2(CW) + 1;
  localparam int RW = $clog2(NW) + 1;

  function automatic logic [BW-1:0] keep_mask(input int idx);
    for (int b = 0; b < BW; b++) keep_mask[b] = (idx * BW + b) < P;
  endfunction

  kara_state_e state;
  logic [KW-1:0] ld_cnt;
  logic          ld_b;
  logic [KW-1:0] mk;
  logic [AW-1:0] mi;
  kara_phase_e   mph;
  logic          issuing;
  logic          s1_v, s1_use, s1_last, s1_final;
  kara_phase_e   s1_ph;
  logic [KW-1:0] s1_k;
  logic [2*BW-1:0] pra, pra_nx, pp;
  logic [RW-1:0] rd_cnt;
  logic [NW*BW-1:0] cvec;

  // load path
  logic          ld_go, ld_tgt_b, ld_hi;
  logic [KW-1:0] ld_idx;
  logic [AW-1:0] ld_addr;
  logic [BW-1:0] ld_data;

  always_comb begin
    ld_go    = (state == ST_LOAD) ||
               (state == ST_IDLE && req_i && (op_i == OPC_LOAD_A || op_i == OPC_LOAD_B));
    ld_idx   = (state == ST_LOAD) ? ld_cnt : '0;
    ld_tgt_b = (state == ST_LOAD) ? ld_b : (op_i == OPC_LOAD_B);
    ld_hi    = int'(ld_idx) >= HW;
    ld_addr  = AW'(ld_hi ? int'(ld_idx) - HW : int'(ld_idx));
    ld_data  = data_i & keep_mask(int'(ld_idx));
  end

  // multiply issue: column mk, A word mi, B word mk-mi
  int            jj;
  logic          use_pp;
  logic [AW-1:0] jaddr;

  always_comb begin
    jj     = int'(mk) - int'(mi);
    use_pp = issuing && jj >= 0 && jj < HW;
    jaddr  = use_pp ? AW'(jj) : '0;
  end

  // memories: 0 A-low, 1 A-high, 2 B-low, 3 B-high
  logic [BW-1:0] mem_rd [4];

  for (genvar g = 0; g < 4; g++) begin : g_mem
    localparam bit IS_B  = (g >= 2);
    localparam bit IS_HI = (g % 2) == 1;
    kara_half_mem #(.DW(BW), .DEPTH(HW), .AW(AW)) u_mem (
      .clk   (clk),
      .we    (ld_go && (ld_tgt_b == IS_B) && (ld_hi == IS_HI)),
      .waddr (ld_addr),
      .wdata (ld_data),
      .raddr (IS_B ? jaddr : mi),
      .rdata (mem_rd[g])
    );
  end

  // stage 1: half-sums folded in on the way to the multiplier
  logic [BW-1:0] a_w, b_w;

  always_comb begin
    unique case (s1_ph)
      PH_LOW:  begin a_w = mem_rd[0]; b_w = mem_rd[2]; end
      PH_HIGH: begin a_w = mem_rd[1]; b_w = mem_rd[3]; end
      default: begin a_w = mem_rd[0] ^ mem_rd[1]; b_w = mem_rd[2] ^ mem_rd[3]; end
    endcase
  end

  kara_clmul #(.BW(BW)) u_clmul (.a(a_w), .b(b_w), .p(pp));

  assign pra_nx = pra ^ (s1_use ? pp : '0);

  kara_result_bank #(.P(P), .BW(BW), .HW(HW), .KW(KW), .NW(NW)) u_bank (
    .clk   (clk),
    .we    (s1_v && s1_last),
    .sel   (s1_ph),
    .waddr (s1_k),
    .wdata (pra_nx[BW-1:0]),
    .cvec  (cvec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      ld_cnt   <= '0;
      ld_b     <= 1'b0;
      mk       <= '0;
      mi       <= '0;
      mph      <= PH_LOW;
      issuing  <= 1'b0;
      s1_v     <= 1'b0;
      s1_use   <= 1'b0;
      s1_last  <= 1'b0;
      s1_final <= 1'b0;
      s1_ph    <= PH_LOW;
      s1_k     <= '0;
      pra      <= '0;
      rd_cnt   <= '0;
      res_o    <= '0;
      valid_o  <= 1'b0;
      ack_o    <= 1'b0;
    end else begin
      ack_o    <= 1'b0;
      valid_o  <= 1'b0;
      s1_v     <= issuing;
      s1_use   <= use_pp;
      s1_ph    <= mph;
      s1_k     <= mk;
      s1_last  <= int'(mi) == HW - 1;
      s1_final <= issuing && mph == PH_HIGH && int'(mk) == CW - 1 && int'(mi) == HW - 1;
      if (s1_v) pra <= s1_last ? (pra_nx >> BW) : pra_nx;

      unique case (state)
        ST_IDLE: begin
          if (req_i) begin
            unique case (op_i)
              OPC_LOAD_A, OPC_LOAD_B: begin
                ld_b   <= (op_i == OPC_LOAD_B);
                ld_cnt <= KW'(1);
                state  <= ST_LOAD;
              end
              OPC_MULT: begin
                issuing <= 1'b1;
                mk      <= '0;
                mi      <= '0;
                mph     <= PH_LOW;
                pra     <= '0;
                state   <= ST_MUL;
              end
              default: begin
                rd_cnt <= '0;
                state  <= ST_READ;
              end
            endcase
          end
        end
        ST_LOAD: begin
          ld_cnt <= ld_cnt + 1'b1;
          if (int'(ld_cnt) == CW - 1) begin
            state <= ST_IDLE;
            ack_o <= 1'b1;
          end
        end
        ST_MUL: begin
          if (issuing) begin
            if (int'(mi) == HW - 1) begin
              mi <= '0;
              if (int'(mk) == CW - 1) begin
                mk <= '0;
                if (mph == PH_HIGH) issuing <= 1'b0;
                else mph <= (mph == PH_LOW) ? PH_MID : PH_HIGH;
              end else begin
                mk <= mk + 1'b1;
              end
            end else begin
              mi <= mi + 1'b1;
            end
          end
          if (s1_v && s1_final) begin
            state <= ST_IDLE;
            ack_o <= 1'b1;
          end
        end
        default: begin
          res_o   <= cvec[int'(rd_cnt)*BW +: BW];
          valid_o <= 1'b1;
          rd_cnt  <= rd_cnt + 1'b1;
          if (int'(rd_cnt) == NW - 1) begin
            state <= ST_IDLE;
            ack_o <= 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/kara_mul_chk.sv
module kara_mul_chk #(
  parameter int P  = 13,
  parameter int BW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          valid_o,
  input logic          ack_o,
  input logic [BW-1:0] res_o
);
  localparam int NW = (P + BW - 1) / BW;
  localparam int VW = $clog2(NW + 1) + 1;

  function automatic logic [BW-1:0] last_keep();
    for (int b = 0; b < BW; b++) last_keep[b] = ((NW - 1) * BW + b) < P;
  endfunction

  logic [VW-1:0] vrun;

  always_ff @(posedge clk) begin
    if (rst) vrun <= '0;
    else     vrun <= valid_o ? vrun + 1'b1 : '0;
  end

  assert_ack_single_R5: assert property (@(posedge clk) disable iff (rst)
    ack_o |=> !ack_o);

  assert_stream_gapless_R4: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !ack_o) |=> valid_o);

  assert_stream_length_R4: assert property (@(posedge clk) disable iff (rst)
    (valid_o && ack_o) |-> (int'(vrun) == NW - 1));

  assert_pad_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (valid_o && ack_o) |-> ((res_o & ~last_keep()) == '0));

  assert_reset_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!valid_o && !ack_o));
endmodule

bind kara_mul kara_mul_chk #(.P(P), .BW(BW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .valid_o (valid_o),
  .ack_o   (ack_o),
  .res_o   (res_o)
);

// File: tb/sim_kara_mul.sv
module sim_kara_mul;
  localparam int P  = 13;
  localparam int BW = 4;
  localparam int NW = (P + BW - 1) / BW;

  logic          clk = 1'b0;
  logic          rst;
  logic          req_i;
  logic [1:0]    op_i;
  logic [BW-1:0] data_i;
  logic [BW-1:0] res_o;
  logic          valid_o;
  logic          ack_o;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;
  int unsigned seed = 32'h1234_5678;

  always #2 clk = ~clk;

  kara_mul #(.P(P), .BW(BW)) u0 (
    .clk(clk), .rst(rst), .req_i(req_i), .op_i(op_i), .data_i(data_i),
    .res_o(res_o), .valid_o(valid_o), .ack_o(ack_o)
  );

  task automatic report(input bit ok, input string tag,
                        input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      report(1'b0, "R5 watchdog expired", 64'(cyc), 64'd0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  function automatic logic [P-1:0] ref_mul(input logic [P-1:0] a, input logic [P-1:0] b);
    logic [P-1:0] r = '0;
    for (int i = 0; i < P; i++)
      for (int j = 0; j < P; j++)
        if (a[i] && b[j]) r[(i + j) % P] ^= 1'b1;
    return r;
  endfunction

  // operand word with padding bits deliberately set to 1 (R2)
  function automatic logic [BW-1:0] word_of(input logic [P-1:0] v, input int w);
    logic [BW-1:0] x;
    for (int b = 0; b < BW; b++) x[b] = (w * BW + b < P) ? v[w*BW + b] : 1'b1;
    return x;
  endfunction

  function automatic logic [P-1:0] rnd();
    seed ^= seed << 13;
    seed ^= seed >> 17;
    seed ^= seed << 5;
    return P'(seed);
  endfunction

  task automatic wait_ack(input string tag);
    int t = 0;
    while (!ack_o && t < 2000) begin
      @(negedge clk);
      t++;
    end
    if (!ack_o) report(1'b0, tag, 64'(t), 64'd0);
    else begin
      @(negedge clk);
      report(!ack_o, "R5 ack lasts one cycle", 64'(ack_o), 64'd0);
    end
  endtask

  task automatic load(input bit is_b, input logic [P-1:0] v);
    @(negedge clk);
    req_i  = 1'b1;
    op_i   = is_b ? 2'd1 : 2'd0;
    data_i = word_of(v, 0);
    for (int w = 1; w < NW; w++) begin
      @(negedge clk);
      req_i  = 1'b0;
      data_i = word_of(v, w);
    end
    @(negedge clk);
    req_i  = 1'b0;
    data_i = '0;
    wait_ack("R1 R2 load ack missing");
  endtask

  task automatic mult(input bit poke);
    @(negedge clk);
    req_i = 1'b1;
    op_i  = 2'd2;
    @(negedge clk);
    req_i = 1'b0;
    if (poke) begin
      @(negedge clk);
      req_i  = 1'b1;
      op_i   = 2'd0;
      data_i = '1;
      @(negedge clk);
      op_i   = 2'd1;
      @(negedge clk);
      op_i   = 2'd3;
      @(negedge clk);
      req_i  = 1'b0;
      data_i = '0;
    end
    wait_ack("R1 multiply ack missing");
  endtask

  task automatic read(output logic [P-1:0] r);
    logic [NW*BW-1:0] acc = '0;
    int got = 0;
    int t = 0;
    bit done = 0;
    @(negedge clk);
    req_i = 1'b1;
    op_i  = 2'd3;
    @(negedge clk);
    req_i = 1'b0;
    while (!done && t < 100) begin
      if (valid_o) begin
        if (got < NW) acc[got*BW +: BW] = res_o;
        got++;
        if (ack_o) begin
          done = 1;
          report((res_o >> (P - (NW - 1) * BW)) == '0, "R4 padding of last word",
                 64'(res_o), 64'(res_o & ((1 << (P - (NW - 1) * BW)) - 1)));
        end
      end
      @(negedge clk);
      t++;
    end
    report(got == NW && done, "R4 readout word count", 64'(got), 64'(NW));
    r = acc[P-1:0];
  endtask

  task automatic run(input logic [P-1:0] a, input logic [P-1:0] b, input string tag);
    logic [P-1:0] r;
    load(1'b0, a);
    load(1'b1, b);
    mult(1'b0);
    read(r);
    report(r == ref_mul(a, b), tag, 64'(r), 64'(ref_mul(a, b)));
  endtask

  initial begin
    logic [P-1:0] a, b, b2, r1, r2;
    rst = 1'b1; req_i = 1'b0; op_i = '0; data_i = '0;
    repeat (4) @(negedge clk);
    report(!valid_o && !ack_o, "R8 outputs during reset", 64'({valid_o, ack_o}), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    report(!valid_o && !ack_o, "R8 outputs after reset", 64'({valid_o, ack_o}), 64'd0);

    // R9 R3 R2: every monomial pair, across the split and past x^P
    for (int ia = 0; ia < P; ia++)
      for (int ib = 0; ib < P; ib++)
        run(P'(1) << ia, P'(1) << ib, "R2 R3 R9 monomial pair");

    for (int k = 0; k < 300; k++) run(rnd(), rnd(), "R3 random operands");
    run('1, '1, "R3 all ones");
    run('0, rnd(), "R3 zero operand");
    run('1, P'(1), "R3 unit operand");

    // R7: keep A, replace B only, read twice
    a = rnd(); b = rnd(); b2 = rnd();
    run(a, b, "R7 first product");
    load(1'b1, b2);
    mult(1'b0);
    read(r1);
    report(r1 == ref_mul(a, b2), "R7 operand A retained", 64'(r1), 64'(ref_mul(a, b2)));
    read(r2);
    report(r2 == r1, "R7 second readout identical", 64'(r2), 64'(r1));

    // R6: requests during a multiply are ignored
    for (int k = 0; k < 4; k++) begin
      a = rnd(); b = rnd();
      load(1'b0, a);
      load(1'b1, b);
      mult(1'b1);
      read(r1);
      report(r1 == ref_mul(a, b), "R6 busy requests ignored", 64'(r1), 64'(ref_mul(a, b)));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule